// File: doc/BRIEF.md
# Sign-Magnitude Recursive Sine Generator

This block produces a stream of sinusoid samples from a two-tap recursion. Two registers hold the latest sample and the one before it. Each new sample is the latest sample multiplied by a loadable coefficient k, with the older sample then subtracted. The coefficient equals twice the cosine of the phase step per sample, so it sets the output frequency: one sinusoid cycle spans about 2π/θ samples. All arithmetic is sign-magnitude fixed point. Negation only flips the sign bit, and the subtraction is a sign-magnitude addition of the older sample with its sign flipped.

Software loads the coefficient and both starting samples with a single strobe and then holds the run enable high. Samples leave on a valid/ready stream. A sample stays on the output until the consumer takes it, and the recursion does not advance while a sample is waiting. The parameter ERR_FB adds a second-order error shaper. It keeps the bits lost in the last two truncations and adds twice the newer residue minus the older one to the next product before that product is truncated, which limits how far the period drifts. The parameter PIPE adds a register on the product path, so each sample takes two cycles.

Top module: `smag_sine_gen`

## Requirements
- R1: Each data word (load_y1, load_y2, out_data) is INT_W+FRAC_W+1 bits wide. The MSB is the sign (1 = negative) and the lower bits are the magnitude with FRAC_W fraction bits. The coefficient word carries its sign in the MSB and a magnitude of COEF_FRAC+1 bits with COEF_FRAC fraction bits. With the default parameters, a coefficient magnitude of 255 represents 255/128.
- R2: When load is high, the coefficient, y(n-1) (load_y1) and y(n-2) (load_y2) are written, the shaper residues are cleared, any pending or in-flight sample is dropped, and out_valid is low in the next cycle. Load wins over run in the same cycle.
- R3: With ERR_FB off, each sample equals trunc(k·y(n-1)) − y(n-2), where trunc cuts the product toward zero to FRAC_W fraction bits. After each sample, y(n-2) takes the old y(n-1) and y(n-1) takes the new sample.
- R4: A result whose magnitude exceeds the largest representable magnitude is replaced by that largest magnitude, and its sign is kept.
- R5: A result with zero magnitude always has sign 0. An input of negative zero acts as zero.
- R6: With ERR_FB on, the value 2·r(n-1) − r(n-2) is added to the full-precision product before truncation. Here r is the signed remainder each truncation discarded. The remainder of the current sum then becomes the newest residue.
- R7: While out_valid is high and out_ready is low, out_data holds still and no new sample is computed. A sample is taken on a cycle where both are high.
- R8: While run is low, no new sample is started and the state is held, so the sequence resumes where it stopped.
- R9: With PIPE off, a step accepted on an edge gives out_valid after that same edge, and steps can follow every cycle. With PIPE on, the sample appears one edge later and a step starts at most every second cycle.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that writes the coefficient and both starting samples |
| load_coef | input | COEF_FRAC+2 | Coefficient k, sign-magnitude |
| load_y1 | input | INT_W+FRAC_W+1 | Starting y(n-1), sign-magnitude |
| load_y2 | input | INT_W+FRAC_W+1 | Starting y(n-2), sign-magnitude |
| run | input | 1 | Allows the recursion to step |
| out_valid | output | 1 | out_data holds a sample not yet taken |
| out_ready | input | 1 | The consumer takes the sample |
| out_data | output | INT_W+FRAC_W+1 | Sample, sign-magnitude |

## Verification
The recursion runs with five coefficients: near 2 (a slow wave of about 71 samples), +1, −1, 0 and about √2. Together they exercise positive and negative products, sign changes on every step, and exact and inexact truncations. Two builds are compared sample by sample against an integer model: plain with no product register, and shaped with the product register. The shaped build only matches if the residue history is kept correctly. One-shot loads drive the adder into positive and negative saturation, into exact cancellation to zero, and into negative-zero operands. Stalls on out_ready, run gaps and a reload in mid-stream show whether the sequence is held, resumed or restarted.

// File: rtl/smag_pkg.sv
package smag_pkg;
  // step state for the registered-product variant
  typedef enum logic [0:0] {
    STEP_IDLE = 1'b0,
    STEP_MUL  = 1'b1
  } step_e;
endpackage

// File: rtl/smag_add.sv
// Sign-magnitude adder: magnitude gets one extra bit, zero is always positive.
module smag_add #(
  parameter int W = 8
) (
  input  logic         a_s,
  input  logic [W-1:0] a_m,
  input  logic         b_s,
  input  logic [W-1:0] b_m,
  output logic         s_s,
  output logic [W:0]   s_m
);
  logic a_ge;

  always_comb begin
    a_ge = (a_m >= b_m);
    if (a_s == b_s) begin
      s_m = {1'b0, a_m} + {1'b0, b_m};
      s_s = a_s;
    end else if (a_ge) begin
      s_m = {1'b0, a_m} - {1'b0, b_m};
      s_s = a_s;
    end else begin
      s_m = {1'b0, b_m} - {1'b0, a_m};
      s_s = b_s;
    end
    if (s_m == '0) s_s = 1'b0;
  end
endmodule

// File: rtl/smag_mult.sv
// Sign-magnitude multiplier: magnitudes multiply, signs xor, zero product positive.
module smag_mult #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            a_s,
  input  logic [AW-1:0]   a_m,
  input  logic            b_s,
  input  logic [BW-1:0]   b_m,
  output logic            p_s,
  output logic [AW+BW-1:0] p_m
);
  assign p_m = {{BW{1'b0}}, a_m} * {{AW{1'b0}}, b_m};
  assign p_s = (a_s ^ b_s) & (|p_m);
endmodule

// File: rtl/smag_err_shaper.sv
// Second-order residue shaper: fb = 2*r(n-1) - r(n-2), or zero when disabled.
module smag_err_shaper #(
  parameter int RW     = 7,
  parameter bit ENABLE = 1'b1,
  localparam int FBM   = RW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          res_s,
  input  logic [RW-1:0] res_m,
  output logic          fb_s,
  output logic [FBM-1:0] fb_m
);
  generate
    if (ENABLE) begin : g_on
      logic          r1_s, r2_s;
      logic [RW-1:0] r1_m, r2_m;
      logic [RW:0]   dbl_m, old_m;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          r1_s <= 1'b0;
          r1_m <= '0;
          r2_s <= 1'b0;
          r2_m <= '0;
        end else if (adv) begin
          r2_s <= r1_s;
          r2_m <= r1_m;
          r1_s <= res_s;
          r1_m <= res_m;
        end
      end

      assign dbl_m = {r1_m, 1'b0};
      assign old_m = {1'b0, r2_m};

      smag_add #(.W(RW + 1)) u_fb_sum (
        .a_s(r1_s), .a_m(dbl_m),
        .b_s(~r2_s), .b_m(old_m),
        .s_s(fb_s), .s_m(fb_m)
      );

      // R6: a cleared history contributes nothing to the next step
      assert_cleared_history_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fb_m == '0));
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, clr, adv, res_s, res_m};
      assign fb_s = 1'b0;
      assign fb_m = '0;
    end
  endgenerate
endmodule

// File: rtl/smag_sine_gen.sv
module smag_sine_gen
  import smag_pkg::*;
#(
  parameter int INT_W     = 1,
  parameter int FRAC_W    = 7,
  parameter int COEF_FRAC = 7,
  parameter bit ERR_FB    = 1'b0,
  parameter bit PIPE      = 1'b0,
  localparam int DW       = INT_W + FRAC_W + 1,
  localparam int CW       = COEF_FRAC + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_coef,
  input  logic [DW-1:0] load_y1,
  input  logic [DW-1:0] load_y2,
  input  logic          run,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int DM  = INT_W + FRAC_W;   // data magnitude bits
  localparam int CM  = COEF_FRAC + 1;    // coefficient magnitude bits
  localparam int PM  = DM + CM;          // full product magnitude
  localparam int WM  = PM + 1;           // product plus feedback
  localparam int RW  = COEF_FRAC;        // discarded fraction bits
  localparam int TM  = WM - RW;          // truncated magnitude
  localparam int FBM = RW + 2;           // feedback magnitude

  logic          y1_s, y2_s, c_s;
  logic [DM-1:0] y1_m, y2_m;
  logic [CM-1:0] c_m;
  logic          valid_q;
  logic [DW-1:0] data_q;

  logic          start, commit, busy, slot_free;

  // product and shaped wide sum
  logic          p_s, w_s, fb_s, st_s;
  logic [PM-1:0] p_m, fb_ext;
  logic [FBM-1:0] fb_m;
  logic [WM-1:0] w_m, st_m;

  // truncation and final add
  logic          t_s, res_s, f_s, ovf, n_s;
  logic [TM-1:0] t_m, y2_ext;
  logic [RW-1:0] res_m;
  logic [TM:0]   f_m;
  logic [DM-1:0] n_m;

  assign slot_free = !valid_q || out_ready;
  assign start     = run && !load && !busy && slot_free;

  smag_mult #(.AW(DM), .BW(CM)) u_mult (
    .a_s(y1_s), .a_m(y1_m),
    .b_s(c_s),  .b_m(c_m),
    .p_s(p_s),  .p_m(p_m)
  );

  smag_err_shaper #(.RW(RW), .ENABLE(ERR_FB)) u_shaper (
    .clk(clk), .rst(rst), .clr(load), .adv(commit),
    .res_s(res_s), .res_m(res_m),
    .fb_s(fb_s), .fb_m(fb_m)
  );

  assign fb_ext = {{(PM - FBM){1'b0}}, fb_m};

  smag_add #(.W(PM)) u_wide_add (
    .a_s(p_s),  .a_m(p_m),
    .b_s(fb_s), .b_m(fb_ext),
    .s_s(w_s),  .s_m(w_m)
  );

  generate
    if (PIPE) begin : g_pipe
      step_e         step_q;
      logic          ws_q;
      logic [WM-1:0] wm_q;

      always_ff @(posedge clk) begin
        if (rst || load)   step_q <= STEP_IDLE;
        else if (start)    step_q <= STEP_MUL;
        else if (commit)   step_q <= STEP_IDLE;
        if (start) begin
          ws_q <= w_s;
          wm_q <= w_m;
        end
      end

      assign busy   = (step_q == STEP_MUL);
      assign commit = busy && !load;
      assign st_s   = ws_q;
      assign st_m   = wm_q;

      // R9: registered product delays the sample by one more edge
      assert_two_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !out_valid);
    end else begin : g_comb
      assign busy   = 1'b0;
      assign commit = start;
      assign st_s   = w_s;
      assign st_m   = w_m;

      // R9: sample follows the accepting edge directly
      assert_one_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> out_valid);
    end
  endgenerate

  // truncate toward zero: drop RW low bits of the magnitude, keep the remainder
  assign t_m   = st_m[WM-1:RW];
  assign t_s   = st_s & (|t_m);
  assign res_m = st_m[RW-1:0];
  assign res_s = st_s & (|res_m);

  assign y2_ext = {{(TM - DM){1'b0}}, y2_m};

  smag_add #(.W(TM)) u_final_add (
    .a_s(t_s),   .a_m(t_m),
    .b_s(~y2_s), .b_m(y2_ext),
    .s_s(f_s),   .s_m(f_m)
  );

  assign ovf = |f_m[TM:DM];
  assign n_m = ovf ? {DM{1'b1}} : f_m[DM-1:0];
  assign n_s = f_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      y1_s    <= 1'b0;
      y1_m    <= '0;
      y2_s    <= 1'b0;
      y2_m    <= '0;
      c_s     <= 1'b0;
      c_m     <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      y1_s    <= load_y1[DW-1];
      y1_m    <= load_y1[DM-1:0];
      y2_s    <= load_y2[DW-1];
      y2_m    <= load_y2[DM-1:0];
      c_s     <= load_coef[CW-1];
      c_m     <= load_coef[CM-1:0];
      valid_q <= 1'b0;
    end else begin
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (commit) begin
        y2_s    <= y1_s;
        y2_m    <= y1_m;
        y1_s    <= n_s;
        y1_m    <= n_m;
        data_q  <= {n_s, n_m};
        valid_q <= 1'b1;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_load_drops_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));

  assert_no_neg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_data[DW-1] && (out_data[DM-1:0] == '0)));

  assert_idle_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !busy && !out_valid) |=> !out_valid);

  assert_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    (commit && ovf) |=> (out_data[DM-1:0] == {DM{1'b1}}));
endmodule

// File: tb/smag_sine_gen_test.sv
module smag_sine_gen_test;
  localparam int I    = 1;
  localparam int F    = 7;
  localparam int CF   = 7;
  localparam int DW   = I + F + 1;
  localparam int CW   = CF + 2;
  localparam int MAXM = (1 << (I + F)) - 1;
  localparam int CSC  = 1 << CF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic run = 1'b0;
  logic ready = 1'b0;
  logic [CW-1:0] lcoef = '0;
  logic [DW-1:0] ly1 = '0, ly2 = '0;
  logic v0, v1;
  logic [DW-1:0] d0, d1;

  int compared = 0;
  int mismatched = 0;
  int cnt0 = 0, cnt1 = 0;
  bit finished = 1'b0;

  // model state: plain build (0) and shaped, registered build (1)
  int m0c, m0y1, m0y2, m0r1, m0r2;
  int m1c, m1y1, m1y2, m1r1, m1r2;

  always #10 clk = ~clk;  // 50 MHz

  smag_sine_gen uut (
    .clk(clk), .rst(rst), .load(load), .load_coef(lcoef),
    .load_y1(ly1), .load_y2(ly2), .run(run),
    .out_valid(v0), .out_ready(ready), .out_data(d0)
  );

  smag_sine_gen #(.ERR_FB(1'b1), .PIPE(1'b1)) uut_fb (
    .clk(clk), .rst(rst), .load(load), .load_coef(lcoef),
    .load_y1(ly1), .load_y2(ly2), .run(run),
    .out_valid(v1), .out_ready(ready), .out_data(d1)
  );

  // R1: sign in MSB, magnitude below it
  function automatic logic [DW-1:0] enc(input int v);
    int m;
    m = (v < 0) ? -v : v;
    return {(v < 0) ? 1'b1 : 1'b0, m[DW-2:0]};
  endfunction

  function automatic logic [CW-1:0] encc(input int v);
    int m;
    m = (v < 0) ? -v : v;
    return {(v < 0) ? 1'b1 : 1'b0, m[CW-2:0]};
  endfunction

  function automatic int dec(input logic [DW-1:0] b);
    int m;
    m = int'(b[DW-2:0]);
    return b[DW-1] ? -m : m;
  endfunction

  function automatic int decc(input logic [CW-1:0] b);
    int m;
    m = int'(b[CW-2:0]);
    return b[CW-1] ? -m : m;
  endfunction

  // integer reference of the recursion (R3, R4, R6)
  task automatic model_step(input bit fbon, input int c, inout int y1, inout int y2,
                            inout int r1, inout int r2, output int y);
    int s, t;
    s = c * y1 + (fbon ? (2 * r1 - r2) : 0);
    t = s / CSC;
    if (fbon) begin
      r2 = r1;
      r1 = s - t * CSC;
    end
    y = t - y2;
    if (y > MAXM) y = MAXM;
    if (y < -MAXM) y = -MAXM;
    y2 = y1;
    y1 = y;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // every taken sample is compared with its model
  always @(negedge clk) begin
    int e;
    if (!rst && v0 && ready) begin
      model_step(1'b0, m0c, m0y1, m0y2, m0r1, m0r2, e);
      cnt0++;
      chk(d0 == enc(e), "R3 plain sample", dec(d0), e);
    end
    if (!rst && v1 && ready) begin
      model_step(1'b1, m1c, m1y1, m1y2, m1r1, m1r2, e);
      cnt1++;
      chk(d1 == enc(e), "R6 shaped sample", dec(d1), e);
    end
  end

  task automatic load_raw(input logic [CW-1:0] c, input logic [DW-1:0] a, input logic [DW-1:0] b);
    tick;
    load = 1'b1;
    lcoef = c;
    ly1 = a;
    ly2 = b;
    tick;
    load = 1'b0;
    m0c = decc(c); m0y1 = dec(a); m0y2 = dec(b); m0r1 = 0; m0r2 = 0;
    m1c = decc(c); m1y1 = dec(a); m1y2 = dec(b); m1r1 = 0; m1r2 = 0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) tick;
    @(negedge clk);
    chk(v0 == 1'b0, "R10 reset valid plain", int'(v0), 0);
    chk(v1 == 1'b0, "R10 reset valid shaped", int'(v1), 0);
    tick;
    rst = 1'b0;
  endtask

  task automatic t_latency;
    load_raw(encc(181), enc(90), enc(0));
    run = 1'b1;
    ready = 1'b0;
    @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, "R9 before step", int'({v0, v1}), 0);
    @(negedge clk);
    chk(v0 == 1'b1 && v1 == 1'b0, "R9 one edge", int'({v0, v1}), 2);
    @(negedge clk);
    chk(v0 == 1'b1 && v1 == 1'b1, "R9 two edges", int'({v0, v1}), 3);
    tick;
    run = 1'b0;
    ready = 1'b1;
    repeat (3) tick;
  endtask

  task automatic t_stream(input int c, input int a, input int b, input int n);
    int s0, s1;
    load_raw(encc(c), enc(a), enc(b));
    s0 = cnt0;
    s1 = cnt1;
    run = 1'b1;
    ready = 1'b1;
    repeat (n) tick;
    run = 1'b0;
    repeat (4) tick;
    chk((cnt0 - s0) == n, "R9 plain rate R3", cnt0 - s0, n);
    chk((cnt1 - s1) == (n + 1) / 2, "R9 shaped rate R6", cnt1 - s1, (n + 1) / 2);
  endtask

  task automatic t_hold;
    logic [DW-1:0] h0, h1;
    load_raw(encc(255), enc(16), enc(0));
    run = 1'b1;
    ready = 1'b0;
    repeat (4) @(negedge clk);
    h0 = d0;
    h1 = d1;
    chk(v0 && v1, "R7 waiting samples", int'({v0, v1}), 3);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(v0 && d0 == h0, "R7 plain held", dec(d0), dec(h0));
      chk(v1 && d1 == h1, "R7 shaped held", dec(d1), dec(h1));
    end
    tick;
    ready = 1'b1;
    repeat (10) tick;
    run = 1'b0;
    repeat (4) tick;
  endtask

  task automatic t_run_low;
    load_raw(encc(255), enc(20), enc(0));
    run = 1'b1;
    ready = 1'b1;
    repeat (12) tick;
    run = 1'b0;
    repeat (3) tick;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!v0 && !v1, "R8 stopped", int'({v0, v1}), 0);
    end
    tick;
    run = 1'b1;
    repeat (12) tick;
    run = 1'b0;
    repeat (4) tick;
  endtask

  task automatic t_load_priority;
    load_raw(encc(128), enc(64), enc(0));
    run = 1'b1;
    ready = 1'b1;
    repeat (9) tick;
    load_raw(encc(-128), enc(50), enc(-20));
    @(negedge clk);
    chk(!v0 && !v1, "R2 load drops sample", int'({v0, v1}), 0);
    repeat (15) tick;
    run = 1'b0;
    repeat (4) tick;
  endtask

  task automatic t_one_shot(input logic [CW-1:0] c, input logic [DW-1:0] a,
                            input logic [DW-1:0] b, input logic [DW-1:0] exp, input string req);
    load_raw(c, a, b);
    run = 1'b1;
    ready = 1'b0;
    repeat (3) tick;
    @(negedge clk);
    chk(v0 && d0 == exp, {req, " plain"}, int'(d0), int'(exp));
    chk(v1 && d1 == exp, {req, " shaped"}, int'(d1), int'(exp));
    tick;
    run = 1'b0;
    ready = 1'b1;
    repeat (3) tick;
  endtask

  initial begin
    t_reset;
    t_latency;
    t_stream(255, 16, 0, 150);
    t_stream(128, 64, 0, 30);
    t_stream(-128, 64, 0, 30);
    t_stream(0, 100, 0, 30);
    t_stream(181, 90, -30, 40);
    t_hold;
    t_run_low;
    t_load_priority;
    // R4 with R1 field positions: clamp to magnitude 255, sign kept
    t_one_shot(encc(255), enc(255), enc(-255), {1'b0, 8'hFF}, "R4 R1 positive clamp");
    t_one_shot(encc(255), enc(-255), enc(255), {1'b1, 8'hFF}, "R4 R1 negative clamp");
    // R5: exact cancel gives +0, negative zero operands act as zero
    t_one_shot(encc(128), enc(-3), enc(-3), {1'b0, 8'h00}, "R5 cancel");
    t_one_shot(encc(128), enc(4), {1'b1, 8'h00}, {1'b0, 8'h04}, "R5 neg zero y2");
    t_one_shot({1'b1, 8'h00}, enc(7), enc(5), {1'b1, 8'h05}, "R5 neg zero coef");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule